// File: doc/BRIEF.md
# Interrupt Pending Flag Bank

This block keeps one pending flag, one enable bit and one 3-bit priority per interrupt source, and turns them into a single request with a level for a CPU. A one-cycle pulse on a source's event input latches that source's flag. Only a software write can clear it. Taking the interrupt does not clear it, so a handler that returns without clearing the flag sees the same request again.

Software reaches four word registers over a simple bus with a write strobe and a combinational read port. A mode bit picks how a write to the flag word acts. In clear-only mode, a 1 bit clears that flag and a 0 bit leaves it alone. In plain mode, the written word becomes the new flag value. The CPU feeds in its 4-bit current interrupt level. The block requests whenever an enabled, pending source has a priority strictly above that level. It reports the highest such priority and the lowest-numbered source that holds it.

Top module: `intr_pend_bank`

## Requirements
- R1: An event pulse on source i (evt_i[i] high for one cycle) sets flag i, and flag i reads 1 from the next cycle on.
- R2: If an event and a software write that would clear the same flag fall in the same cycle, the flag ends up set.
- R3: After reset, the mode register (address 2, bit 0) reads 1 (clear-only mode), the enable register reads 0, and the priority register reads 0.
- R4: In clear-only mode (mode bit 1), a write to the flag register (address 0) clears every flag whose data bit is 1. A flag whose data bit is 0 keeps its value, and no write can set a flag.
- R5: In plain mode (mode bit 0), a write to the flag register loads the data bits: written 1 sets the flag and written 0 clears it.
- R6: A set flag stays set without a flag write, including while and after the CPU level is raised above its priority, so the request comes back when the level drops again.
- R7: irq_req is 1 exactly when some source has flag = 1, enable = 1 and a priority strictly greater than cpu_level. When irq_req is 0, irq_level and irq_src are 0.
- R8: irq_level is the largest priority among the requesting sources, and irq_src is the lowest source index that has that priority.
- R9: Reads have no side effects. Address 0 returns the flags in bits [N-1:0], address 1 returns the enables in bits [N-1:0], address 2 returns the mode in bit 0, and address 3 returns the priority of source i in bits [4i+2:4i].
- R10: Writes to the enable, mode and priority registers take effect in the next cycle. Bits with no register behind them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | NUM_SRC | Per-source event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 flags, 1 enables, 2 mode, 3 priorities |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_level | input | 4 | CPU current interrupt level |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 4 | Level of the winning request |
| irq_src | output | 3 | Index of the winning source |

## Verification
The hardest case to reach is an event and a clearing write arriving on the same flag in the same cycle. The stimulus drives the event pulse and the bus write on the same falling edge, so both meet at one rising edge. It does this in both write modes. The other hard case is re-request after service, because the flags have no reset and acceptance leaves no trace in them. The bench first clears the flags through the bus. It then raises cpu_level to the served level and drops it again, and checks that the request returns with the flag still set.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  localparam int DATA_W  = 32;
  localparam int PSTRIDE = 4;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_MODE = 2'd2,
    SEL_PRIO = 2'd3
  } ipb_sel_e;
endpackage

// File: rtl/ipb_flags.sv
module ipb_flags #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_flag,
  input  logic               clr_only,
  input  logic [NUM_SRC-1:0] wd_flag,
  output logic [NUM_SRC-1:0] flag_q
);
  logic [NUM_SRC-1:0] flag_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_flag) begin
      if (clr_only) flag_d = flag_q & ~wd_flag;
      else          flag_d = wd_flag;
    end
    flag_d = flag_d | evt_i;
  end

  // No reset term: software clears the flags after power-up.
  always_ff @(posedge clk) begin
    flag_q <= flag_d;
  end
endmodule

// File: rtl/ipb_cfg.sv
module ipb_cfg #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_mode,
  input  logic                      wr_prio,
  input  logic [NUM_SRC-1:0]        wd_en,
  input  logic                      wd_mode,
  input  logic [NUM_SRC*PRIO_W-1:0] wd_prio,
  output logic [NUM_SRC-1:0]        en_q,
  output logic                      mode_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_q
);
  logic [NUM_SRC-1:0]        en_d;
  logic                      mode_d;
  logic [NUM_SRC*PRIO_W-1:0] prio_d;

  always_comb begin
    en_d   = wr_en   ? wd_en   : en_q;
    mode_d = wr_mode ? wd_mode : mode_q;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign prio_d[i*PRIO_W +: PRIO_W] =
      wr_prio ? wd_prio[i*PRIO_W +: PRIO_W] : prio_q[i*PRIO_W +: PRIO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b1;
      prio_q <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      prio_q <= prio_d;
    end
  end
endmodule

// File: rtl/ipb_arb.sv
module ipb_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int LVL_W   = 4,
  parameter int SRC_W   = 3
) (
  input  logic [NUM_SRC-1:0]        flag_q,
  input  logic [NUM_SRC-1:0]        en_q,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_q,
  input  logic [LVL_W-1:0]          cpu_level,
  output logic                      irq_req,
  output logic [LVL_W-1:0]          irq_level,
  output logic [SRC_W-1:0]          irq_src
);
  logic              hit;
  logic [PRIO_W-1:0] best_p;
  logic [SRC_W-1:0]  best_s;
  logic [PRIO_W-1:0] cand_p;

  // Ascending scan with strict compare: the lowest index keeps a tie.
  always_comb begin
    hit    = 1'b0;
    best_p = '0;
    best_s = '0;
    cand_p = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      cand_p = prio_q[i*PRIO_W +: PRIO_W];
      if (flag_q[i] && en_q[i] && (LVL_W'(cand_p) > cpu_level) &&
          (!hit || cand_p > best_p)) begin
        hit    = 1'b1;
        best_p = cand_p;
        best_s = SRC_W'(i);
      end
    end
  end

  assign irq_req   = hit;
  assign irq_level = hit ? LVL_W'(best_p) : '0;
  assign irq_src   = hit ? best_s : '0;
endmodule

// File: rtl/intr_pend_bank.sv
module intr_pend_bank
  import ipb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int LVL_W   = 4,
  parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [LVL_W-1:0]   cpu_level,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [SRC_W-1:0]   irq_src
);
  logic [1:0]                rst_q;
  logic                      rst_sync_n;
  logic [NUM_SRC-1:0]        flag_q;
  logic [NUM_SRC-1:0]        en_q;
  logic                      mode_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [NUM_SRC*PRIO_W-1:0] wd_prio;
  logic [DATA_W-1:0]         prio_rd;
  logic                      wr_flag, wr_en, wr_mode, wr_prio;
  logic                      unused_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_comb begin
    wr_flag = bus_wr && (bus_addr == SEL_FLAG);
    wr_en   = bus_wr && (bus_addr == SEL_EN);
    wr_mode = bus_wr && (bus_addr == SEL_MODE);
    wr_prio = bus_wr && (bus_addr == SEL_PRIO);
  end

  always_comb begin
    wd_prio = '0;
    prio_rd = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      wd_prio[i*PRIO_W +: PRIO_W]  = bus_wdata[i*PSTRIDE +: PRIO_W];
      prio_rd[i*PSTRIDE +: PRIO_W] = prio_q[i*PRIO_W +: PRIO_W];
    end
  end

  assign unused_wd = ^bus_wdata;

  ipb_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk      (clk),
    .evt_i    (evt_i),
    .wr_flag  (wr_flag),
    .clr_only (mode_q),
    .wd_flag  (bus_wdata[NUM_SRC-1:0]),
    .flag_q   (flag_q)
  );

  ipb_cfg #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_mode (wr_mode),
    .wr_prio (wr_prio),
    .wd_en   (bus_wdata[NUM_SRC-1:0]),
    .wd_mode (bus_wdata[0]),
    .wd_prio (wd_prio),
    .en_q    (en_q),
    .mode_q  (mode_q),
    .prio_q  (prio_q)
  );

  ipb_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_arb (
    .flag_q    (flag_q),
    .en_q      (en_q),
    .prio_q    (prio_q),
    .cpu_level (cpu_level),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_src   (irq_src)
  );

  always_comb begin
    unique case (bus_addr)
      SEL_FLAG: bus_rdata = DATA_W'(flag_q);
      SEL_EN:   bus_rdata = DATA_W'(en_q);
      SEL_MODE: bus_rdata = DATA_W'(mode_q);
      default:  bus_rdata = prio_rd;
    endcase
  end
endmodule

// File: rtl/ipb_chk.sv
module ipb_chk #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter int SRC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               bus_wr,
  input logic [1:0]         bus_addr,
  input logic [NUM_SRC-1:0] wd_flag,
  input logic [NUM_SRC-1:0] flag_q,
  input logic               mode_q,
  input logic [LVL_W-1:0]   cpu_level,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_level,
  input logic [SRC_W-1:0]   irq_src
);
  logic flag_wr;
  assign flag_wr = bus_wr && (bus_addr == 2'd0);

  // R1 and R2: an event always leaves its flag set
  a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R4: zero data bits leave flags unchanged in clear-only mode
  a_r4_zero_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && mode_q) |=>
      (((flag_q ^ $past(flag_q)) & ~$past(wd_flag) & ~$past(evt_i)) == '0));

  // R4: software cannot set a flag in clear-only mode
  a_r4_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && mode_q) |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0));

  // R6: no flag drops without a flag write
  a_r6_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (($past(flag_q) & ~flag_q) == '0));

  // R7: a request is always above the CPU level
  a_r7_req_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > cpu_level));

  // R7: idle outputs are zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0 && irq_src == '0));
endmodule

bind intr_pend_bank ipb_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .evt_i     (evt_i),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wd_flag   (bus_wdata[NUM_SRC-1:0]),
  .flag_q    (flag_q),
  .mode_q    (mode_q),
  .cpu_level (cpu_level),
  .irq_req   (irq_req),
  .irq_level (irq_level),
  .irq_src   (irq_src)
);

// File: tb/sim_intr_pend_bank.sv
module sim_intr_pend_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  cpu_level;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [2:0]  irq_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  intr_pend_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_level(cpu_level), .irq_req(irq_req), .irq_level(irq_level),
    .irq_src(irq_src)
  );

  typedef struct packed {
    logic [7:0]  flags;
    logic [7:0]  en;
    logic [31:0] prio;
    logic [3:0]  lvl;
    logic        req;
    logic [3:0]  olvl;
    logic [2:0]  src;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'h01, 32'h0000_0005, 4'd0, 1'b1, 4'd5, 3'd0},
    '{8'h0F, 8'h0A, 32'h0000_7365, 4'd0, 1'b1, 4'd7, 3'd3},
    '{8'h0F, 8'h0A, 32'h0000_7365, 4'd7, 1'b0, 4'd0, 3'd0},
    '{8'hFF, 8'hFF, 32'h3333_3333, 4'd2, 1'b1, 4'd3, 3'd0},
    '{8'h90, 8'hF0, 32'h4000_0400, 4'd3, 1'b1, 4'd4, 3'd7},
    '{8'h80, 8'h00, 32'h7000_0000, 4'd0, 1'b0, 4'd0, 3'd0},
    '{8'h24, 8'h24, 32'h0060_0600, 4'd5, 1'b1, 4'd6, 3'd2}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(logic [7:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse_wr(logic [7:0] e, logic [31:0] d);
    @(negedge clk);
    evt_i = e; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = d;
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0;
  endtask

  task automatic chk_irq(string tag, logic r, logic [3:0] l, logic [2:0] s);
    #1;
    chk({tag, " req"}, 32'(irq_req), 32'(r));
    chk({tag, " level"}, 32'(irq_level), 32'(l));
    chk({tag, " src"}, 32'(irq_src), 32'(s));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] d2;
    rst_n = 1'b0; evt_i = '0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; cpu_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd(2'd2, d); chk("R3 mode after reset", d, 32'h1);
    rd(2'd1, d); chk("R3 enables after reset", d, 32'h0);
    rd(2'd3, d); chk("R3 priorities after reset", d, 32'h0);

    wr(2'd0, 32'hFF);
    rd(2'd0, d); chk("R4 clear all flags", d, 32'h0);
    chk_irq("R7 idle", 1'b0, 4'd0, 3'd0);

    pulse(8'h0A);
    rd(2'd0, d); chk("R1 events set flags", d, 32'h0A);
    wr(2'd0, 32'h02);
    rd(2'd0, d); chk("R4 write one clears only that bit", d, 32'h08);
    wr(2'd0, 32'h05);
    rd(2'd0, d); chk("R4 no software set", d, 32'h08);

    pulse_wr(8'h08, 32'h08);
    rd(2'd0, d); chk("R2 set wins over clear (clear-only mode)", d, 32'h08);

    @(negedge clk); evt_i = 8'h40;
    @(negedge clk); evt_i = '0;
    #1 bus_addr = 2'd0; #1 chk("R1 flag visible next cycle", bus_rdata, 32'h48);

    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R10 mode write", d, 32'h0);
    wr(2'd0, 32'h31);
    rd(2'd0, d); chk("R5 plain write sets", d, 32'h31);
    wr(2'd0, 32'h10);
    rd(2'd0, d); chk("R5 plain write clears zeros", d, 32'h10);
    pulse_wr(8'h02, 32'h0);
    rd(2'd0, d); chk("R2 set wins over clear (plain mode)", d, 32'h02);

    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R10 priority unused bits read 0", d, 32'h7777_7777);
    wr(2'd1, 32'hFFFF_FF5A);
    rd(2'd1, d); chk("R10 enable write", d, 32'h5A);
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd2, d); chk("R10 mode keeps only bit 0", d, 32'h0);

    wr(2'd1, 32'h01);
    wr(2'd3, 32'h5);
    wr(2'd0, 32'h01);
    chk_irq("R7 single source", 1'b1, 4'd5, 3'd0);
    @(negedge clk); cpu_level = 4'd5;
    chk_irq("R6 served level masks", 1'b0, 4'd0, 3'd0);
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R6 flag survives service", d, 32'h01);
    @(negedge clk); cpu_level = 4'd0;
    chk_irq("R6 request returns", 1'b1, 4'd5, 3'd0);

    rd(2'd0, d); rd(2'd0, d2);
    chk("R9 repeated read same", d2, d);
    chk_irq("R9 read leaves request", 1'b1, 4'd5, 3'd0);

    for (int k = 0; k < NV; k++) begin
      wr(2'd1, 32'(VECS[k].en));
      wr(2'd3, VECS[k].prio);
      wr(2'd0, 32'(VECS[k].flags));
      @(negedge clk); cpu_level = VECS[k].lvl;
      rd(2'd0, d); chk($sformatf("R9 flags vec%0d", k), d, 32'(VECS[k].flags));
      chk_irq($sformatf("R7 R8 vec%0d", k), VECS[k].req, VECS[k].olvl, VECS[k].src);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule